// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Segment Preload and Rounding

This block multiplies two 16-bit operands and keeps the result in a 35-bit output register. The result can replace the register contents, be added to them, or have them subtracted from it. The operands are read either as two's complement or as unsigned values. An optional rounding term adds one at the top bit of the low half. The output register is split into three segments: a 3-bit extension, a 16-bit upper half and a 16-bit lower half. Each segment has its own active-low output enable. Each segment can also be written directly from outside through a preload path, so an accumulation can start from any chosen value.

Everything runs on one clock, and three load strobes replace separate clocks. `load_x` and `load_y` capture the operands. Either of them also latches the mode bits: accumulate, subtract, signed and round. `load_p` writes the output register. Drivers that would share a bus are modelled as a data output plus an enable output. The lower segment shares its preload path with the Y operand bus.

Top module: `mac16_unit`

## Requirements
- R1: After reset, the output register, both operand registers and the latched mode bits are all zero.
- R2: `x_in` is captured into the X operand register only on a cycle with `load_x`=1, and `y_in` into the Y operand register only on a cycle with `load_y`=1. Otherwise each register holds.
- R3: `acc`, `sub`, `tc` and `rnd` are latched on any cycle with `load_x` or `load_y` high. Changing these pins on other cycles has no effect on later results.
- R4: With latched accumulate = 0, a `load_p` (with `prel`=0) writes the product alone, and the latched subtract bit has no effect.
- R5: With latched accumulate = 1 and subtract = 0, a `load_p` writes the product plus the previous output register value, modulo 2^35.
- R6: With latched accumulate = 1 and subtract = 1, a `load_p` writes the product minus the previous output register value, modulo 2^35.
- R7: With latched `tc`=1 both operands are two's complement and the 32-bit product is sign-extended to 35 bits. With `tc`=0 both operands are unsigned and the product is zero-extended.
- R8: With latched `rnd`=1, 2^15 is added to the value written by an arithmetic `load_p`. With `rnd`=0 nothing is added.
- R9: The output register changes only on cycles with `load_p`=1.
- R10: A `load_p` with `prel`=1 writes bits 34..32 from `ext_in`, bits 31..16 from `hi_in` and bits 15..0 from `y_in`.
- R11: With `prel`=0, the values on `ext_in` and `hi_in` have no effect on the output register.
- R12: The enable outputs `ext_oe`, `hi_oe` and `lo_oe` are each high exactly when the matching active-low input `ext_oe_n`, `hi_oe_n` or `lo_oe_n` is 0. The enables are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_x | input | 1 | Capture X operand; also latches mode bits |
| load_y | input | 1 | Capture Y operand; also latches mode bits |
| load_p | input | 1 | Write the output register |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand, also lower-segment preload data |
| acc | input | 1 | Accumulate mode |
| sub | input | 1 | Subtract mode (used when accumulating) |
| tc | input | 1 | Two's complement operands |
| rnd | input | 1 | Add rounding term at bit 15 |
| prel | input | 1 | Preload the output register from the ports |
| ext_in | input | 3 | Extension-segment preload data |
| hi_in | input | 16 | Upper-segment preload data |
| ext_oe_n | input | 1 | Extension segment output enable, active low |
| hi_oe_n | input | 1 | Upper segment output enable, active low |
| lo_oe_n | input | 1 | Lower segment output enable, active low |
| ext_out | output | 3 | Output register bits 34..32 |
| hi_out | output | 16 | Output register bits 31..16 |
| lo_out | output | 16 | Output register bits 15..0 |
| ext_oe | output | 1 | Extension segment drive enable |
| hi_oe | output | 1 | Upper segment drive enable |
| lo_oe | output | 1 | Lower segment drive enable |

## Verification
Directed operand pairs cover several cases:
- A negative times a positive operand, once as signed and once as unsigned, which separates sign extension from zero extension.
- Full-scale unsigned operands, which show that no stray bits reach the extension segment.
- A preload followed by an accumulate, and a preload followed by a subtract. These show the direction of the subtraction and that the preloaded value feeds the next operation.
- Pin changes made without a load strobe, which show that the mode bits are latched and that the output register holds its value.

Random sequences then mix load strobes, modes, preloads and output enables, and compare every cycle against a bench model.

// File: rtl/mac16_unit.sv
module mac16_unit #(
  parameter int OPW  = 16,
  parameter int EXTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_x,
  input  logic            load_y,
  input  logic            load_p,
  input  logic [OPW-1:0]  x_in,
  input  logic [OPW-1:0]  y_in,
  input  logic            acc,
  input  logic            sub,
  input  logic            tc,
  input  logic            rnd,
  input  logic            prel,
  input  logic [EXTW-1:0] ext_in,
  input  logic [OPW-1:0]  hi_in,
  input  logic            ext_oe_n,
  input  logic            hi_oe_n,
  input  logic            lo_oe_n,
  output logic [EXTW-1:0] ext_out,
  output logic [OPW-1:0]  hi_out,
  output logic [OPW-1:0]  lo_out,
  output logic            ext_oe,
  output logic            hi_oe,
  output logic            lo_oe
);
  localparam int PRW = 2*OPW;
  localparam int PW  = PRW + EXTW;

  logic [OPW-1:0] xr, yr;
  logic           acc_q, sub_q, tc_q, rnd_q;
  logic [PW-1:0]  p_q;

  logic signed [PRW-1:0] sprod;
  logic        [PRW-1:0] uprod;
  logic        [PW-1:0]  prod, sum, rnd_term, p_next;

  assign sprod = $signed(xr) * $signed(yr);
  assign uprod = xr * yr;
  assign prod  = tc_q ? {{EXTW{sprod[PRW-1]}}, sprod} : {{EXTW{1'b0}}, uprod};
  assign rnd_term = rnd_q ? (PW'(1) << (OPW-1)) : '0;

  always_comb begin
    if (!acc_q)     sum = prod;
    else if (sub_q) sum = prod - p_q;
    else            sum = prod + p_q;
    p_next = prel ? {ext_in, hi_in, y_in} : sum + rnd_term;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xr    <= '0;
      yr    <= '0;
      acc_q <= 1'b0;
      sub_q <= 1'b0;
      tc_q  <= 1'b0;
      rnd_q <= 1'b0;
      p_q   <= '0;
    end else begin
      if (load_x) xr <= x_in;
      if (load_y) yr <= y_in;
      if (load_x || load_y) begin
        acc_q <= acc;
        sub_q <= sub;
        tc_q  <= tc;
        rnd_q <= rnd;
      end
      if (load_p) p_q <= p_next;
    end
  end

  assign ext_out = p_q[PW-1:PRW];
  assign hi_out  = p_q[PRW-1:OPW];
  assign lo_out  = p_q[OPW-1:0];
  assign ext_oe  = ~ext_oe_n;
  assign hi_oe   = ~hi_oe_n;
  assign lo_oe   = ~lo_oe_n;
endmodule

// File: rtl/mac16_unit_chk.sv
module mac16_unit_chk #(
  parameter int OPW  = 16,
  parameter int EXTW = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load_x,
  input logic                    load_y,
  input logic                    load_p,
  input logic                    prel,
  input logic [OPW-1:0]          xr,
  input logic [OPW-1:0]          yr,
  input logic                    acc_q,
  input logic                    sub_q,
  input logic                    tc_q,
  input logic                    rnd_q,
  input logic [EXTW-1:0]         ext_in,
  input logic [OPW-1:0]          hi_in,
  input logic [OPW-1:0]          y_in,
  input logic [EXTW-1:0]         ext_out,
  input logic [OPW-1:0]          hi_out,
  input logic [OPW-1:0]          lo_out
);
  localparam int PRW = 2*OPW;
  localparam int PW  = PRW + EXTW;

  logic [PW-1:0] pv, ref_prod;
  logic signed [PRW-1:0] s;
  logic        [PRW-1:0] u;

  assign pv = {ext_out, hi_out, lo_out};

  always_comb begin
    s = $signed(xr) * $signed(yr);
    u = xr * yr;
    ref_prod = tc_q ? {{EXTW{s[PRW-1]}}, s} : {{EXTW{1'b0}}, u};
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_p |=> $stable(pv));

  a_r10_preload: assert property (@(posedge clk) disable iff (!rst_n)
    load_p && prel |=> pv == $past({ext_in, hi_in, y_in}));

  a_r2_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_x |=> $stable(xr));

  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_x || load_y) |=> $stable({acc_q, sub_q, tc_q, rnd_q}));

  a_r4_plain: assert property (@(posedge clk) disable iff (!rst_n)
    load_p && !prel && !acc_q && !rnd_q |=> pv == $past(ref_prod));

  a_r5_add: assert property (@(posedge clk) disable iff (!rst_n)
    load_p && !prel && acc_q && !sub_q && !rnd_q |=> pv == $past(ref_prod + pv));

  a_r6_sub: assert property (@(posedge clk) disable iff (!rst_n)
    load_p && !prel && acc_q && sub_q && !rnd_q |=> pv == $past(ref_prod - pv));
endmodule

bind mac16_unit mac16_unit_chk #(.OPW(OPW), .EXTW(EXTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_x(load_x), .load_y(load_y), .load_p(load_p),
  .prel(prel), .xr(xr), .yr(yr), .acc_q(acc_q), .sub_q(sub_q), .tc_q(tc_q),
  .rnd_q(rnd_q), .ext_in(ext_in), .hi_in(hi_in), .y_in(y_in),
  .ext_out(ext_out), .hi_out(hi_out), .lo_out(lo_out)
);

// File: tb/mac16_unit_tb_top.sv
module mac16_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic load_x = 0, load_y = 0, load_p = 0;
  logic [15:0] x_in = 0, y_in = 0, hi_in = 0;
  logic [2:0]  ext_in = 0;
  logic acc = 0, sub = 0, tc = 0, rnd = 0, prel = 0;
  logic ext_oe_n = 1, hi_oe_n = 1, lo_oe_n = 1;
  logic [2:0]  ext_out;
  logic [15:0] hi_out, lo_out;
  logic ext_oe, hi_oe, lo_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] m_x = 0, m_y = 0;
  logic m_acc = 0, m_sub = 0, m_tc = 0, m_rnd = 0;
  logic [34:0] m_p = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac16_unit dut_i (
    .clk(clk), .rst_n(rst_n), .load_x(load_x), .load_y(load_y), .load_p(load_p),
    .x_in(x_in), .y_in(y_in), .acc(acc), .sub(sub), .tc(tc), .rnd(rnd),
    .prel(prel), .ext_in(ext_in), .hi_in(hi_in), .ext_oe_n(ext_oe_n),
    .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n), .ext_out(ext_out), .hi_out(hi_out),
    .lo_out(lo_out), .ext_oe(ext_oe), .hi_oe(hi_oe), .lo_oe(lo_oe)
  );

  function automatic logic [34:0] f_prod(logic [15:0] a, logic [15:0] b, logic sgn);
    logic signed [31:0] s;
    logic [31:0] u;
    s = $signed(a) * $signed(b);
    u = a * b;
    return sgn ? {{3{s[31]}}, s} : {3'b000, u};
  endfunction

  function automatic logic [34:0] f_mac(logic [15:0] a, logic [15:0] b, logic sgn,
                                        logic ac, logic sb, logic rd, logic [34:0] p);
    logic [34:0] pr, r;
    pr = f_prod(a, b, sgn);
    r = !ac ? pr : (sb ? pr - p : pr + p);
    return r + (rd ? 35'h8000 : 35'h0);
  endfunction

  task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit lx, bit ly, bit lp);
    load_x = lx; load_y = ly; load_p = lp;
    @(posedge clk);
    if (lp) m_p = prel ? {ext_in, hi_in, y_in} : f_mac(m_x, m_y, m_tc, m_acc, m_sub, m_rnd, m_p);
    if (lx) m_x = x_in;
    if (ly) m_y = y_in;
    if (lx || ly) begin m_acc = acc; m_sub = sub; m_tc = tc; m_rnd = rnd; end
    @(negedge clk);
    load_x = 0; load_y = 0; load_p = 0;
    chk(tag, {ext_out, hi_out, lo_out}, m_p);
  endtask

  task automatic setop(logic [15:0] a, logic [15:0] b, bit ac, bit sb, bit sg, bit rd);
    x_in = a; y_in = b; acc = ac; sub = sb; tc = sg; rnd = rd; prel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset", {ext_out, hi_out, lo_out}, 35'h0);

    setop(16'd3, 16'd5, 0, 1, 0, 0);
    step("R2 load", 1, 1, 0);
    step("R4 plain", 0, 0, 1);
    chk("R4 plain value", {ext_out, hi_out, lo_out}, 35'd15);

    setop(16'hFFFE, 16'd3, 0, 0, 1, 0);
    step("R2 load", 1, 1, 0);
    step("R7 signed", 0, 0, 1);
    chk("R7 signed value", {ext_out, hi_out, lo_out}, 35'h7FFFFFFFA);
    setop(16'hFFFE, 16'd3, 0, 0, 0, 0);
    step("R3 latch tc", 1, 0, 0);
    step("R7 unsigned", 0, 0, 1);
    chk("R7 unsigned value", {ext_out, hi_out, lo_out}, 35'd196602);

    setop(16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
    step("R2 load", 1, 1, 0);
    step("R7 full scale", 0, 0, 1);
    chk("R7 full scale value", {ext_out, hi_out, lo_out}, 35'h0FFFE0001);

    setop(16'd1, 16'd1, 0, 0, 0, 1);
    step("R8 load", 1, 1, 0);
    step("R8 round", 0, 0, 1);
    chk("R8 round value", {ext_out, hi_out, lo_out}, 35'h8001);

    setop(16'd2, 16'd7, 0, 0, 0, 0);
    step("R2 load x only", 1, 0, 0);
    step("R2 y held", 0, 0, 1);
    chk("R2 y held value", {ext_out, hi_out, lo_out}, 35'd2);

    prel = 1; ext_in = 3'd5; hi_in = 16'h1234; y_in = 16'hABCD;
    step("R10 preload", 0, 0, 1);
    chk("R10 preload value", {ext_out, hi_out, lo_out}, {3'd5, 16'h1234, 16'hABCD});
    setop(16'd2, 16'd3, 1, 0, 0, 0);
    step("R3 load acc", 1, 1, 0);
    acc = 0; sub = 1;
    step("R5 accumulate after preload", 0, 0, 1);
    chk("R5 value", {ext_out, hi_out, lo_out}, {3'd5, 16'h1234, 16'hABCD} + 35'd6);

    prel = 1; ext_in = 3'd1; hi_in = 16'h0000; y_in = 16'h0010;
    step("R10 preload", 0, 0, 1);
    setop(16'd2, 16'd3, 1, 1, 0, 0);
    step("R3 load sub", 1, 1, 0);
    step("R6 subtract after preload", 0, 0, 1);
    chk("R6 value", {ext_out, hi_out, lo_out}, 35'd6 - 35'h100000010);

    setop(16'd9, 16'd9, 0, 0, 0, 0);
    step("R2 load", 1, 1, 0);
    ext_in = 3'd7; hi_in = 16'hFFFF;
    step("R11 prel low", 0, 0, 1);
    chk("R11 value", {ext_out, hi_out, lo_out}, 35'd81);
    x_in = 16'h5555; y_in = 16'h7777; acc = 1; rnd = 1;
    step("R9 no load_p", 0, 0, 0);
    step("R9 no load_p again", 0, 0, 0);

    for (int k = 0; k < 8; k++) begin
      {ext_oe_n, hi_oe_n, lo_oe_n} = k[2:0];
      #1;
      checks++;
      if ({ext_oe, hi_oe, lo_oe} !== ~k[2:0]) begin
        failures++;
        $display("FAIL R12 actual=%b expected=%b", {ext_oe, hi_oe, lo_oe}, ~k[2:0]);
      end
    end
    @(negedge clk);

    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      bit lx, ly, lp;
      string tag;
      x_in = 16'($urandom); y_in = 16'($urandom); hi_in = 16'($urandom);
      ext_in = 3'($urandom);
      acc = 1'($urandom); sub = 1'($urandom); tc = 1'($urandom); rnd = 1'($urandom);
      prel = ($urandom % 8) == 0;
      {ext_oe_n, hi_oe_n, lo_oe_n} = 3'($urandom);
      lx = 1'($urandom); ly = 1'($urandom); lp = 1'($urandom);
      if (!lp) tag = "R9 random hold";
      else if (prel) tag = "R10 random preload";
      else if (!m_acc) tag = "R4 random plain";
      else if (m_sub) tag = "R6 random subtract";
      else tag = "R5 random accumulate";
      step(tag, lx, ly, lp);
      checks++;
      if ({ext_oe, hi_oe, lo_oe} !== ~{ext_oe_n, hi_oe_n, lo_oe_n}) begin
        failures++;
        $display("FAIL R12 actual=%b expected=%b", {ext_oe, hi_oe, lo_oe}, ~{ext_oe_n, hi_oe_n, lo_oe_n});
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule